// File: doc/BRIEF.md
# Private-First Last-Level-Cache Request Router

This controller steers one last-level-cache lookup at a time through a banked cache whose banks hold two kinds of lines. Some lines are private to a single core and sit in one of the four banks nearest that core. Others are shared and sit in the bank picked by the line address alone. A request arrives with the requesting core number and the line address. The controller probes the requester's own private bank first. If that misses, it probes the shared bank. If that also misses, it sends one broadcast probe to the private banks of every other core and, in the same cycle, a read request to memory.

A copy found in another core's private bank is turned into a shared line. The controller issues a migration command that moves it from that bank into its shared bank. A line that comes back from memory is written into the requester's private bank as a private line. Every response to the requester carries a shared/private bit, so that a later write-back can be aimed at the right bank. When the on-chip copy and the memory reply both arrive, the on-chip copy wins. The memory reply is then absorbed and thrown away, and the controller stays busy until it has arrived.

The states are ST_IDLE, ST_PRIV_ISSUE, ST_PRIV_WAIT, ST_SH_ISSUE, ST_SH_WAIT, ST_BCAST, ST_REM_WAIT, ST_MEM_WAIT, ST_MIGRATE, ST_FILL, ST_RESP and ST_DRAIN. The transitions are:

- ST_IDLE goes to ST_PRIV_ISSUE when a request is accepted.
- ST_PRIV_ISSUE goes to ST_PRIV_WAIT.
- ST_PRIV_WAIT goes to ST_RESP on a hit and to ST_SH_ISSUE on a miss.
- ST_SH_ISSUE goes to ST_SH_WAIT.
- ST_SH_WAIT goes to ST_RESP on a hit and to ST_BCAST on a miss.
- ST_BCAST goes to ST_REM_WAIT.
- ST_REM_WAIT goes to ST_MIGRATE on a remote hit. On a remote miss it goes to ST_FILL if memory has already answered, and to ST_MEM_WAIT if it has not.
- ST_MEM_WAIT goes to ST_FILL.
- ST_MIGRATE and ST_FILL go to ST_RESP.
- ST_RESP goes to ST_IDLE. After a remote hit whose memory reply is still outstanding, it goes to ST_DRAIN instead.
- ST_DRAIN goes to ST_IDLE when the memory reply arrives.

Top module: `llc_route_ctrl`

## Requirements
- R1: `busy` rises in the cycle after a request is accepted and falls in the cycle after the response cycle, or after the drain. A request presented while `busy` is high is ignored and does not change the line under lookup.
- R2: The first command is a single-cycle bank probe to the requester's private bank, numbered core*4 + line[1:0]. It carries the request line on `cmd_line`.
- R3: A private-bank hit produces one response cycle with `rsp_shared`=0 and `rsp_level`=0 (private).
- R4: A private-bank miss leads to a single-cycle probe of the shared bank, numbered line[4:0]. A hit there answers with `rsp_shared`=1 and `rsp_level`=1 (shared).
- R5: A shared-bank miss raises `remote_probe_valid` and `mem_req_valid` together for one cycle. `remote_mask` then has a bit set for every core except the requester, with bit i standing for core i. At most one of the bank probe, remote probe, migration and fill commands is active in any cycle.
- R6: A remote hit reported by core c issues one migration command from bank c*4 + line[1:0] to bank line[4:0]. The response then has `rsp_shared`=1 and `rsp_level`=2 (remote).
- R7: A remote miss waits for the memory reply. It then issues one fill command to the requester's private bank and answers with `rsp_shared`=0 and `rsp_level`=3 (memory).
- R8: A remote hit wins over a memory reply that arrives before it, in the same cycle or after it. A memory reply still missing at the response holds `busy` high until it arrives.
- R9: After reset `busy` and every command and response valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New lookup request |
| req_core | input | 3 | Requesting core |
| req_line | input | 26 | Line address of the request |
| busy | output | 1 | A lookup is in progress |
| cmd_line | output | 26 | Line address for every command |
| probe_valid | output | 1 | Single bank probe |
| probe_bank | output | 5 | Bank addressed by the probe |
| bank_rsp_valid | input | 1 | Bank probe answer |
| bank_rsp_hit | input | 1 | Bank probe hit |
| remote_probe_valid | output | 1 | Broadcast to the other cores' private banks |
| remote_mask | output | 8 | Cores addressed by the broadcast |
| mem_req_valid | output | 1 | Memory read request |
| remote_rsp_valid | input | 1 | Combined answer of the remote banks |
| remote_rsp_hit | input | 1 | A remote private bank holds the line |
| remote_rsp_core | input | 3 | Core whose bank holds the line |
| mem_rsp_valid | input | 1 | Memory data returned |
| mig_valid | output | 1 | Migration command |
| mig_src_bank | output | 5 | Private bank giving up the line |
| mig_dst_bank | output | 5 | Shared bank receiving the line |
| fill_valid | output | 1 | Fill command from memory |
| fill_bank | output | 5 | Private bank receiving the fill |
| rsp_valid | output | 1 | Response to the requester |
| rsp_shared | output | 1 | Line is shared (1) or private (0) |
| rsp_level | output | 2 | Where the line was found: 0 private, 1 shared, 2 remote, 3 memory |

## Verification
The remote-bank answer and the memory reply race each other, and both can land in the same cycle of ST_REM_WAIT. The bench provokes this race in three orders: memory first, both together, and memory last. For each order it also tries a remote hit and a remote miss. For a remote hit, the test passes when a migration command follows and no fill appears. It also checks that `busy` stays high in the memory-last order until the stray reply has come. For a remote miss, the test passes when exactly one fill follows, whether the memory reply came first, together with the remote answer, or later.

// File: rtl/llc_route_pkg.sv
package llc_route_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRIV_ISSUE,
        ST_PRIV_WAIT,
        ST_SH_ISSUE,
        ST_SH_WAIT,
        ST_BCAST,
        ST_REM_WAIT,
        ST_MEM_WAIT,
        ST_MIGRATE,
        ST_FILL,
        ST_RESP,
        ST_DRAIN
    } route_state_t;

    typedef enum logic [1:0] {
        LVL_PRIV   = 2'd0,
        LVL_SHARED = 2'd1,
        LVL_REMOTE = 2'd2,
        LVL_MEM    = 2'd3
    } hit_level_t;

endpackage

// File: rtl/llc_bank_map.sv
// Bank numbering: a private bank is {core, low line bits}, a shared bank is
// the low line bits alone. Also builds the broadcast mask of the other cores.
module llc_bank_map #(
    parameter int NCORES = 8,
    parameter int CORE_W = 3,
    parameter int PSEL_W = 2,
    localparam int BANK_W = CORE_W + PSEL_W
) (
    input  logic [CORE_W-1:0] own_core,
    input  logic [CORE_W-1:0] holder_core,
    input  logic [BANK_W-1:0] line_lo,
    output logic [BANK_W-1:0] own_bank,
    output logic [BANK_W-1:0] holder_bank,
    output logic [BANK_W-1:0] shared_bank,
    output logic [NCORES-1:0] other_mask
);
    assign own_bank    = {own_core, line_lo[PSEL_W-1:0]};
    assign holder_bank = {holder_core, line_lo[PSEL_W-1:0]};
    assign shared_bank = line_lo;

    for (genvar i = 0; i < NCORES; i++) begin : g_mask
        assign other_mask[i] = (own_core != CORE_W'(i));
    end
endmodule

// File: rtl/llc_mem_tracker.sv
// Remembers whether the memory reply of the current lookup has come back.
module llc_mem_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    output logic seen
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) seen <= 1'b0;
        else if (capture)    seen <= 1'b1;
    end
endmodule

// File: rtl/llc_route_ctrl.sv
module llc_route_ctrl
    import llc_route_pkg::*;
#(
    parameter int NCORES     = 8,
    parameter int PRIV_BANKS = 4,
    parameter int LINE_W     = 26,
    localparam int CORE_W = $clog2(NCORES),
    localparam int PSEL_W = $clog2(PRIV_BANKS),
    localparam int BANK_W = CORE_W + PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LINE_W-1:0] req_line,
    output logic              busy,
    output logic [LINE_W-1:0] cmd_line,
    output logic              probe_valid,
    output logic [BANK_W-1:0] probe_bank,
    input  logic              bank_rsp_valid,
    input  logic              bank_rsp_hit,
    output logic              remote_probe_valid,
    output logic [NCORES-1:0] remote_mask,
    output logic              mem_req_valid,
    input  logic              remote_rsp_valid,
    input  logic              remote_rsp_hit,
    input  logic [CORE_W-1:0] remote_rsp_core,
    input  logic              mem_rsp_valid,
    output logic              mig_valid,
    output logic [BANK_W-1:0] mig_src_bank,
    output logic [BANK_W-1:0] mig_dst_bank,
    output logic              fill_valid,
    output logic [BANK_W-1:0] fill_bank,
    output logic              rsp_valid,
    output logic              rsp_shared,
    output logic [1:0]        rsp_level
);
    route_state_t      state, state_nx;
    hit_level_t        lvl_q, lvl_nx;
    logic [CORE_W-1:0] core_q, holder_q;
    logic [LINE_W-1:0] line_q;
    logic              accept, mem_seen;
    logic [BANK_W-1:0] own_bank, holder_bank, shared_bank;
    logic [NCORES-1:0] other_mask;

    assign accept = (state == ST_IDLE) && req_valid;

    llc_bank_map #(.NCORES(NCORES), .CORE_W(CORE_W), .PSEL_W(PSEL_W)) map_i (
        .own_core    (core_q),
        .holder_core (holder_q),
        .line_lo     (line_q[BANK_W-1:0]),
        .own_bank    (own_bank),
        .holder_bank (holder_bank),
        .shared_bank (shared_bank),
        .other_mask  (other_mask)
    );

    // A memory reply is tracked only while a lookup is in flight.
    llc_mem_tracker mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (mem_rsp_valid && (state != ST_IDLE)),
        .seen    (mem_seen)
    );

    // State register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lvl_q    <= LVL_PRIV;
            core_q   <= '0;
            holder_q <= '0;
            line_q   <= '0;
        end else begin
            state <= state_nx;
            lvl_q <= lvl_nx;
            if (accept) begin
                core_q <= req_core;
                line_q <= req_line;
            end
            if (state == ST_REM_WAIT && remote_rsp_valid && remote_rsp_hit)
                holder_q <= remote_rsp_core;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        lvl_nx   = lvl_q;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_PRIV_ISSUE;
            ST_PRIV_ISSUE: state_nx = ST_PRIV_WAIT;
            ST_PRIV_WAIT:
                if (bank_rsp_valid) begin
                    if (bank_rsp_hit) begin
                        state_nx = ST_RESP;
                        lvl_nx   = LVL_PRIV;
                    end else begin
                        state_nx = ST_SH_ISSUE;
                    end
                end
            ST_SH_ISSUE:   state_nx = ST_SH_WAIT;
            ST_SH_WAIT:
                if (bank_rsp_valid) begin
                    if (bank_rsp_hit) begin
                        state_nx = ST_RESP;
                        lvl_nx   = LVL_SHARED;
                    end else begin
                        state_nx = ST_BCAST;
                    end
                end
            ST_BCAST:      state_nx = ST_REM_WAIT;
            ST_REM_WAIT:
                if (remote_rsp_valid) begin
                    if (remote_rsp_hit) begin
                        state_nx = ST_MIGRATE;
                        lvl_nx   = LVL_REMOTE;
                    end else begin
                        lvl_nx   = LVL_MEM;
                        state_nx = (mem_seen || mem_rsp_valid) ? ST_FILL : ST_MEM_WAIT;
                    end
                end
            ST_MEM_WAIT:   if (mem_rsp_valid) state_nx = ST_FILL;
            ST_MIGRATE:    state_nx = ST_RESP;
            ST_FILL:       state_nx = ST_RESP;
            ST_RESP:
                if (lvl_q == LVL_REMOTE && !(mem_seen || mem_rsp_valid))
                    state_nx = ST_DRAIN;
                else
                    state_nx = ST_IDLE;
            ST_DRAIN:      if (mem_rsp_valid) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy               = (state != ST_IDLE);
        cmd_line           = line_q;
        probe_valid        = 1'b0;
        probe_bank         = own_bank;
        remote_probe_valid = 1'b0;
        remote_mask        = other_mask;
        mem_req_valid      = 1'b0;
        mig_valid          = 1'b0;
        mig_src_bank       = holder_bank;
        mig_dst_bank       = shared_bank;
        fill_valid         = 1'b0;
        fill_bank          = own_bank;
        rsp_valid          = 1'b0;
        rsp_shared         = (lvl_q == LVL_SHARED) || (lvl_q == LVL_REMOTE);
        rsp_level          = lvl_q;
        unique case (state)
            ST_PRIV_ISSUE: probe_valid = 1'b1;
            ST_SH_ISSUE: begin
                probe_valid = 1'b1;
                probe_bank  = shared_bank;
            end
            ST_BCAST: begin
                remote_probe_valid = 1'b1;
                mem_req_valid      = 1'b1;
            end
            ST_MIGRATE: mig_valid  = 1'b1;
            ST_FILL:    fill_valid = 1'b1;
            ST_RESP:    rsp_valid  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/llc_route_ctrl_chk.sv
module llc_route_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic probe_valid,
    input logic remote_probe_valid,
    input logic mig_valid,
    input logic fill_valid,
    input logic rsp_valid,
    input logic rsp_shared
);
    // R1
    resp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R2
    accept_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> probe_valid);

    // R5
    one_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({probe_valid, remote_probe_valid, mig_valid, fill_valid}));

    // R6
    migrate_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |=> (rsp_valid && rsp_shared));

    // R7
    fill_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (rsp_valid && !rsp_shared));
endmodule

bind llc_route_ctrl llc_route_ctrl_chk chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .req_valid          (req_valid),
    .busy               (busy),
    .probe_valid        (probe_valid),
    .remote_probe_valid (remote_probe_valid),
    .mig_valid          (mig_valid),
    .fill_valid         (fill_valid),
    .rsp_valid          (rsp_valid),
    .rsp_shared         (rsp_shared)
);

// File: tb/llc_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module llc_route_ctrl_tb_top;
    localparam int LINE_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_core = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic              busy;
    logic [LINE_W-1:0] cmd_line;
    logic              probe_valid;
    logic [4:0]        probe_bank;
    logic              bank_rsp_valid = 1'b0;
    logic              bank_rsp_hit = 1'b0;
    logic              remote_probe_valid;
    logic [7:0]        remote_mask;
    logic              mem_req_valid;
    logic              remote_rsp_valid = 1'b0;
    logic              remote_rsp_hit = 1'b0;
    logic [2:0]        remote_rsp_core = '0;
    logic              mem_rsp_valid = 1'b0;
    logic              mig_valid;
    logic [4:0]        mig_src_bank, mig_dst_bank;
    logic              fill_valid;
    logic [4:0]        fill_bank;
    logic              rsp_valid, rsp_shared;
    logic [1:0]        rsp_level;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    llc_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_line(req_line), .busy(busy), .cmd_line(cmd_line),
        .probe_valid(probe_valid), .probe_bank(probe_bank),
        .bank_rsp_valid(bank_rsp_valid), .bank_rsp_hit(bank_rsp_hit),
        .remote_probe_valid(remote_probe_valid), .remote_mask(remote_mask),
        .mem_req_valid(mem_req_valid), .remote_rsp_valid(remote_rsp_valid),
        .remote_rsp_hit(remote_rsp_hit), .remote_rsp_core(remote_rsp_core),
        .mem_rsp_valid(mem_rsp_valid), .mig_valid(mig_valid),
        .mig_src_bank(mig_src_bank), .mig_dst_bank(mig_dst_bank),
        .fill_valid(fill_valid), .fill_bank(fill_bank), .rsp_valid(rsp_valid),
        .rsp_shared(rsp_shared), .rsp_level(rsp_level)
    );

    function automatic int exp_priv(input int core, input logic [LINE_W-1:0] line);
        return core * 4 + int'(line[1:0]);
    endfunction

    function automatic int exp_shared(input logic [LINE_W-1:0] line);
        return int'(line[4:0]);
    endfunction

    function automatic int exp_mask(input int core);
        return 8'hFF & ~(1 << core);
    endfunction

    task automatic ceq(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic check_resp(input string tag, input int shared, input int lvl);
        ceq({tag, " rsp_valid"}, rsp_valid, 1);
        ceq({tag, " rsp_shared"}, rsp_shared, shared);
        ceq({tag, " rsp_level"}, rsp_level, lvl);
    endtask

    // kind: 0 private hit, 1 shared hit, 2 remote hit, 3 memory fill
    // mode: 0 memory before remote answer, 1 same cycle, 2 memory after
    task automatic run_req(input int core, input logic [LINE_W-1:0] line,
                           input int kind, input int mode, input int rcore,
                           input int d, input bit poke);
        req_valid = 1'b1; req_core = 3'(core); req_line = line;
        @(negedge clk);
        req_valid = 1'b0;
        ceq("R1 busy after accept", busy, 1);
        ceq("R2 private probe valid", probe_valid, 1);
        ceq("R2 private probe bank", probe_bank, exp_priv(core, line));
        ceq("R2 probe line", cmd_line, line);
        @(negedge clk);
        if (poke) begin
            req_valid = 1'b1; req_core = 3'(core ^ 1); req_line = ~line;
        end
        repeat (d) @(negedge clk);
        req_valid = 1'b0;
        bank_rsp_valid = 1'b1; bank_rsp_hit = (kind == 0);
        @(negedge clk);
        bank_rsp_valid = 1'b0; bank_rsp_hit = 1'b0;
        if (kind == 0) begin
            check_resp("R3 private hit", 0, 0);
            @(negedge clk);
            ceq("R1 idle after private hit", busy, 0);
            return;
        end
        ceq("R4 shared probe valid", probe_valid, 1);
        ceq("R4 shared probe bank", probe_bank, exp_shared(line));
        ceq("R1 line kept while busy", cmd_line, line);
        @(negedge clk);
        repeat (d) @(negedge clk);
        bank_rsp_valid = 1'b1; bank_rsp_hit = (kind == 1);
        @(negedge clk);
        bank_rsp_valid = 1'b0; bank_rsp_hit = 1'b0;
        if (kind == 1) begin
            check_resp("R4 shared hit", 1, 1);
            @(negedge clk);
            ceq("R1 idle after shared hit", busy, 0);
            return;
        end
        ceq("R5 remote probe", remote_probe_valid, 1);
        ceq("R5 memory request", mem_req_valid, 1);
        ceq("R5 remote mask", remote_mask, exp_mask(core));
        @(negedge clk);
        remote_rsp_hit = (kind == 2); remote_rsp_core = 3'(rcore);
        if (mode == 0) begin
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            repeat (d) @(negedge clk);
            remote_rsp_valid = 1'b1;
            @(negedge clk);
        end else if (mode == 1) begin
            mem_rsp_valid = 1'b1; remote_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end else begin
            remote_rsp_valid = 1'b1;
            @(negedge clk);
        end
        remote_rsp_valid = 1'b0; remote_rsp_hit = 1'b0;
        if (kind == 2) begin
            ceq("R8 migrate not fill", fill_valid, 0);
            ceq("R6 migrate valid", mig_valid, 1);
            ceq("R6 migrate source", mig_src_bank, exp_priv(rcore, line));
            ceq("R6 migrate dest", mig_dst_bank, exp_shared(line));
            @(negedge clk);
            check_resp("R6 remote hit", 1, 2);
            @(negedge clk);
            if (mode == 2) begin
                ceq("R8 drain busy", busy, 1);
                ceq("R8 drain no fill", fill_valid, 0);
                repeat (d) @(negedge clk);
                ceq("R8 drain still busy", busy, 1);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
            ceq("R8 idle after remote hit", busy, 0);
        end else begin
            if (mode == 2) begin
                ceq("R7 no fill before memory", fill_valid, 0);
                repeat (d) @(negedge clk);
                ceq("R7 still waiting", fill_valid, 0);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
            ceq("R7 fill valid", fill_valid, 1);
            ceq("R7 fill bank", fill_bank, exp_priv(core, line));
            @(negedge clk);
            check_resp("R7 memory fill", 0, 3);
            @(negedge clk);
            ceq("R1 idle after fill", busy, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        ceq("R9 reset busy", busy, 0);
        ceq("R9 reset probe", probe_valid, 0);
        ceq("R9 reset remote", remote_probe_valid, 0);
        ceq("R9 reset rsp", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ceq("R9 idle after reset", busy, 0);

        // Directed: every path, every race order, boundary cores
        run_req(0, 26'h000_0000, 0, 0, 1, 0, 1'b0);
        run_req(7, 26'h3FF_FFFF, 1, 0, 0, 1, 1'b0);
        run_req(3, 26'h012_3456, 0, 0, 1, 2, 1'b1);
        run_req(5, 26'h0AB_CDEF, 1, 0, 2, 3, 1'b1);
        for (int m = 0; m < 3; m++) begin
            run_req(0, 26'h155_5555, 2, m, 7, 2, 1'b0);
            run_req(7, 26'h2AA_AAAA, 2, m, 0, 1, 1'b0);
            run_req(2, 26'h0F0_F0F3, 3, m, 1, 2, 1'b0);
            run_req(6, 26'h00F_0F1C, 3, m, 4, 0, 1'b1);
        end

        // Random mix
        for (int n = 0; n < 80; n++) begin
            int core, kind, mode, rcore, d;
            logic [LINE_W-1:0] line;
            core  = int'($urandom % 8);
            kind  = int'($urandom % 4);
            mode  = int'($urandom % 3);
            rcore = (core + 1 + int'($urandom % 7)) % 8;
            d     = int'($urandom % 4);
            line  = LINE_W'($urandom);
            run_req(core, line, kind, mode, rcore, d, (d >= 1) && ($urandom % 2 == 0));
            repeat (int'($urandom % 2)) @(negedge clk);
        end
        finish_run();
    end
endmodule